// File: doc/BRIEF.md
# Multi-Operation Integer Multiply Unit

This block is a single-cycle multiply datapath with a registered output stage. Each cycle it can take two 32-bit operands, a third 32-bit operand used as an addend or subtrahend, a 3-bit operation code and a flag-update request. It returns the 32-bit low word of the result and, for the 64-bit forms, a high word. Two condition flags report a negative result and a zero result.

It handles five operations: a truncating multiply, multiply then add, multiply then subtract, and widening multiplies that treat the operands as either unsigned or two's complement. A single widened product feeds every operation. The selected result goes into output registers one clock after the operands arrive. A new operation can be issued on every cycle, so issue never stalls.

Instruction decode, the register file and writeback steering are handled elsewhere. An upstream stage drives the ports with the decoded fields and a valid strobe.

Top module: `imul_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. A new operation is accepted on every cycle, with no stall between consecutive operations.
- R2: Operation code 3'b000 (truncating multiply) returns the product of `op_a` and `op_b` modulo 2^32 on `res_lo`. It drives `res_hi` to zero, as do codes 3'b001 and 3'b010.
- R3: For code 3'b000, the `res_lo` value equals the low 32 bits of the product of the operands read as two's complement numbers.
- R4: Code 3'b001 returns the low 32 bits of `op_a * op_b + op_c` on `res_lo`.
- R5: Code 3'b010 returns the low 32 bits of `op_a * op_b - op_c` on `res_lo`.
- R6: Code 3'b011 multiplies the operands as unsigned numbers into a 64-bit product. Bits 31:0 go to `res_lo` and bits 63:32 go to `res_hi`.
- R7: Code 3'b100 multiplies the operands as two's complement numbers into a 64-bit product, split across `res_lo` and `res_hi` in the same way as R6.
- R8: The flags change only after a valid cycle that has `set_flags` high and a legal code. In every other case they hold their values.
- R9: After a flag update, `flag_n` is bit 31 of the result (bit 63 for codes 3'b011 and 3'b100). `flag_z` is high exactly when the whole result, 32-bit or 64-bit, is zero.
- R10: Codes 3'b101 to 3'b111 produce `out_valid` high with `res_lo` and `res_hi` both zero. They leave the flags unchanged even when `set_flags` is high.
- R11: A low `rst_n` at a clock edge clears `res_lo`, `res_hi`, `flag_n`, `flag_z` and `out_valid`.
- R12: After a cycle with `in_valid` low, `res_lo` and `res_hi` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op | input | 3 | Operation code |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| op_c | input | 32 | Addend or subtrahend |
| set_flags | input | 1 | Request flag update for this operation |
| out_valid | output | 1 | Registered result is new this cycle |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 for the widening forms, zero otherwise |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hardest cases to reach from the ports involve results that depend on the sign and carry edges of the product. One is a widening product whose high word turns negative, or comes to zero while the low word does not. Another is an accumulate that wraps past 2^32 and lands exactly on zero. Random operands almost never hit these, so the stimulus first sweeps every code against every pairing of 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, using the same set for the third operand. Random traffic then runs with `set_flags` toggled, idle cycles mixed in and a reset in mid-stream. This shows that the flags and results hold across cycles that must not disturb them.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'b000,
    OP_MLA   = 3'b001,
    OP_MLS   = 3'b010,
    OP_UMULL = 3'b011,
    OP_SMULL = 3'b100
  } imul_op_e;

  // Any code above the last defined operation is treated as illegal.
  function automatic logic op_is_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  // These codes write a 64-bit result across both output words.
  function automatic logic op_is_long(input logic [2:0] code);
    return (code == OP_UMULL) || (code == OP_SMULL);
  endfunction

  // Only this code sign-extends its operands before multiplying.
  function automatic logic op_is_signed(input logic [2:0] code);
    return code == OP_SMULL;
  endfunction

endpackage

// File: rtl/imul_product.sv
module imul_product #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] a_ext;
  logic [2*W-1:0] b_ext;

  // Extend each operand to double width. The product taken modulo 2^(2W)
  // then comes out right for both readings of the operands.
  assign a_ext = {{W{sgn & a[W-1]}}, a};
  assign b_ext = {{W{sgn & b[W-1]}}, b};
  assign prod  = a_ext * b_ext;
endmodule

// File: rtl/imul_select.sv
module imul_select #(
  parameter int W = 32
) (
  input  logic [2:0]     op,
  input  logic [2*W-1:0] prod,
  input  logic [W-1:0]   c,
  output logic [W-1:0]   lo,
  output logic [W-1:0]   hi,
  output logic           wide
);
  import imul_pkg::*;

  logic [W-1:0] p_lo;
  logic [W-1:0] p_hi;
  assign p_lo = prod[W-1:0];
  assign p_hi = prod[2*W-1:W];

  always_comb begin
    lo   = '0;
    hi   = '0;
    wide = 1'b0;
    unique case (op)
      OP_MUL:   lo = p_lo;
      OP_MLA:   lo = p_lo + c;
      OP_MLS:   lo = p_lo - c;
      OP_UMULL,
      OP_SMULL: begin
        lo   = p_lo;
        hi   = p_hi;
        wide = 1'b1;
      end
      default:  ;
    endcase
  end
endmodule

// File: rtl/imul_flags.sv
module imul_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         wide,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         flag_n,
  output logic         flag_z
);
  logic n_next;
  logic z_next;

  assign n_next = wide ? hi[W-1] : lo[W-1];
  assign z_next = wide ? ((hi == '0) && (lo == '0)) : (lo == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (we) begin
      flag_n <= n_next;
      flag_z <= z_next;
    end
  end
endmodule

// File: rtl/imul_unit.sv
module imul_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic         set_flags,
  output logic         out_valid,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         flag_n,
  output logic         flag_z
);
  import imul_pkg::*;

  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  sel_lo;
  logic [W-1:0]  sel_hi;
  logic          sel_wide;
  logic          op_legal;
  logic          flag_we;
  logic          res_we;
  logic          armed;

  assign op_legal = op_is_legal(op);
  assign res_we   = in_valid;
  assign flag_we  = in_valid & set_flags & op_legal;

  imul_product #(.W(W)) u_prod (
    .a    (op_a),
    .b    (op_b),
    .sgn  (op_is_signed(op)),
    .prod (prod)
  );

  imul_select #(.W(W)) u_sel (
    .op   (op),
    .prod (prod),
    .c    (op_c),
    .lo   (sel_lo),
    .hi   (sel_hi),
    .wide (sel_wide)
  );

  imul_flags #(.W(W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (flag_we),
    .wide   (sel_wide),
    .lo     (sel_lo),
    .hi     (sel_hi),
    .flag_n (flag_n),
    .flag_z (flag_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      out_valid <= in_valid;
      if (res_we) begin
        res_lo <= sel_lo;
        res_hi <= sel_hi;
      end
    end
  end

  // Rises one cycle after reset is released, so every $past below has a defined value.
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));  // R1

  AST_SHORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && op_is_legal(op) && !op_is_long(op))) |-> (res_hi == '0));  // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(flag_we)) |-> ($stable(flag_n) && $stable(flag_z)));  // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(flag_we)) |-> (flag_z == ((res_hi == '0) && (res_lo == '0))));  // R9

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && !op_is_legal(op))) |-> ((res_lo == '0) && (res_hi == '0)));  // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid)) |-> ($stable(res_lo) && $stable(res_hi)));  // R12

endmodule

// File: tb/imul_unit_bench.sv
`timescale 1ns/100ps
module imul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0;
  logic        set_flags = 1'b0;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;
  logic        flag_n, flag_z;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state: what the outputs must show after the next rising edge.
  bit        e_v, e_n, e_z;
  bit [31:0] e_lo, e_hi;
  string     t_v, t_res, t_flag;

  always #2.5 clk = ~clk;

  imul_unit u_imul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .set_flags(set_flags),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic check_outputs();
    checks++;
    if (out_valid !== e_v) begin
      errors++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", t_v, out_valid, e_v);
    end
    checks++;
    if (res_lo !== e_lo || res_hi !== e_hi) begin
      errors++;
      $display("FAIL %s result actual=%h_%h expected=%h_%h", t_res, res_hi, res_lo, e_hi, e_lo);
    end
    checks++;
    if (flag_n !== e_n || flag_z !== e_z) begin
      errors++;
      $display("FAIL %s flags actual n=%0b z=%0b expected n=%0b z=%0b", t_flag, flag_n, flag_z, e_n, e_z);
    end
  endtask

  task automatic model(input bit rst, input bit v, input bit [2:0] o,
                       input bit [31:0] a, input bit [31:0] b, input bit [31:0] c, input bit sf);
    longint    sa, sb;
    bit [63:0] full;
    bit        legal, long_op;
    if (!rst) begin
      e_v = 0; e_lo = 0; e_hi = 0; e_n = 0; e_z = 0;
      t_v = "R11"; t_res = "R11"; t_flag = "R11";
      return;
    end
    t_v = "R1";
    if (!v) begin
      e_v = 0; t_res = "R12"; t_flag = "R8";
      return;
    end
    e_v = 1;
    sa = $signed(a);
    sb = $signed(b);
    legal = 1; long_op = 0; full = 0;
    case (o)
      3'd0: begin full = sa * sb; e_lo = full[31:0]; e_hi = 0; t_res = "R2 R3"; end
      3'd1: begin e_lo = a * b + c; e_hi = 0; t_res = "R4"; end
      3'd2: begin e_lo = a * b - c; e_hi = 0; t_res = "R5"; end
      3'd3: begin full = {32'b0, a} * {32'b0, b}; e_lo = full[31:0]; e_hi = full[63:32];
                  long_op = 1; t_res = "R6"; end
      3'd4: begin full = sa * sb; e_lo = full[31:0]; e_hi = full[63:32];
                  long_op = 1; t_res = "R7"; end
      default: begin e_lo = 0; e_hi = 0; legal = 0; t_res = "R10"; end
    endcase
    if (legal && sf) begin
      e_n = long_op ? e_hi[31] : e_lo[31];
      e_z = ({e_hi, e_lo} == 64'd0);
      t_flag = "R9";
    end else begin
      t_flag = legal ? "R8" : "R10";
    end
  endtask

  // One cycle: check what the last edge produced, advance the model, drive new inputs.
  task automatic step(input bit rst, input bit v, input bit [2:0] o,
                      input bit [31:0] a, input bit [31:0] b, input bit [31:0] c, input bit sf);
    @(negedge clk);
    if (done) return;
    check_outputs();
    model(rst, v, o, a, b, c, sf);
    rst_n = rst; in_valid = v; op = o; op_a = a; op_b = b; op_c = c; set_flags = sf;
  endtask

  initial begin
    bit [31:0] corner [5];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'h7FFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'hFFFF_FFFF;

    // Reset state (R11)
    e_v = 0; e_lo = 0; e_hi = 0; e_n = 0; e_z = 0;
    t_v = "R11"; t_res = "R11"; t_flag = "R11";
    @(negedge clk);
    model(0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);

    // Corner sweep over every code, operand pair and third operand (R2..R10)
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          step(1, 1, 3'(o), corner[i], corner[j], corner[(i + j + o) % 5], ((i + j) % 3) != 0);

    // Accumulate that wraps to exactly zero, and subtract that lands on zero (R4, R5, R9)
    step(1, 1, 3'd1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1);
    step(1, 1, 3'd2, 32'h0001_0000, 32'h0001_0000, 32'h0000_0000, 1);
    step(1, 1, 3'd2, 32'h0000_0003, 32'h0000_0005, 32'h0000_000F, 1);
    // Widening product: high word negative, and high word zero with low word nonzero (R6, R7, R9)
    step(1, 1, 3'd4, 32'h8000_0000, 32'h0000_0002, 0, 1);
    step(1, 1, 3'd3, 32'h0000_FFFF, 32'h0000_FFFF, 0, 1);
    // Illegal code with set_flags high leaves the flags alone (R10)
    step(1, 1, 3'd7, 32'h1234_5678, 32'h9ABC_DEF0, 0, 1);
    // Idle cycles hold result and flags (R12, R8)
    step(1, 0, 3'd0, 32'hDEAD_BEEF, 32'h1, 0, 1);
    step(1, 0, 3'd1, 32'h1, 32'h1, 32'h1, 1);

    // Random traffic, back-to-back with occasional gaps and one mid-run reset (R1)
    for (int k = 0; k < 4000; k++)
      step(k != 2000, ($urandom % 5) != 0, 3'($urandom % 8),
           $urandom, $urandom, $urandom, $urandom % 2);

    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule